// File: doc/BRIEF.md
# Ordered Key Unlock Sequencer

This block controls access to a protected information region of a flash array. Software has to write a fixed series of 32-bit key words to a single write-only register before access is granted. The keys must arrive in exactly the right order, one write strobe per key. When the last key arrives, the block raises a registered access-granted flag. The surrounding flash controller uses that flag to allow reads and writes of the protected region.

While access is granted, any further write to the register withdraws it, whatever the value written. If a write does not carry the expected key, the sequence is abandoned. The exception is a write that carries the first key: it always counts as the first step of a new attempt. Reads of the register return zero in every state, so the keys cannot be read back.

Top module: `keyseq_unlock`

## Requirements
- R1: While reset is high and after it is released, the grant output is 0 and no partial progress remains. Writing only the second and third keys after reset does not grant access.
- R2: Three consecutive key writes of 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 set the grant output to 1.
- R3: The grant output changes on the clock edge that samples the completing write or the relocking write, and not earlier. Just before that edge it still holds its old value.
- R4: A write of a value that is not the expected key, at either the second or the third step, returns the sequencer to its start. The remaining keys then do not grant access on their own.
- R5: A wrong write whose value equals the first key (0x3A7F5CA3) counts as the first step. For example, first key, first key, second key, third key grants access.
- R6: While access is granted, a write of any value drops the grant output to 0 on the next edge. This includes the third key and the first key.
- R7: After a relock, the sequencer starts from no progress. The relocking write never counts as a step, even when its value is the first key.
- R8: Cycles with the write strobe low change neither the progress nor the grant output, whatever is on the write data bus.
- R9: The read data output is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_wr_i | input | 1 | Write strobe addressed to the key register |
| key_wdata_i | input | 32 | Write data |
| key_rdata_o | output | 32 | Read data of the key register, always zero |
| access_grant_o | output | 1 | Registered access-granted flag for the flash controller |

## Verification
The bench writes a first key in the middle of a sequence. A design that simply reset on any mismatch would then miss the grant for the sequence first, first, second, third.

It relocks with the first key. A design that treated that relocking write as step one would unlock again after only two more keys.

It interleaves idle cycles, with random values on the data bus, between the key writes. A sequencer that advanced without the strobe, or lost its progress during idle cycles, would show the wrong grant.

It also samples the grant output just before and just after the completing edge. This catches an output that is combinational, or that is one cycle late.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;

    localparam int unsigned KEY_W    = 32;
    localparam int unsigned KEY_CNT  = 3;

    // Keys in the order they must be written; entry 0 is written first.
    localparam logic [KEY_CNT-1:0][KEY_W-1:0] KEY_SET = {
        32'h9608_B2C1,
        32'hA1E3_4F20,
        32'h3A7F_5CA3
    };

    typedef struct packed {
        logic wr;
        logic hit_expected;
        logic hit_first;
    } key_event_t;

endpackage

// File: rtl/keyseq_match.sv
module keyseq_match
    import keyseq_pkg::*;
#(
    parameter int unsigned DATA_W   = KEY_W,
    parameter int unsigned NUM_KEYS = KEY_CNT,
    parameter logic [NUM_KEYS-1:0][DATA_W-1:0] KEYS = KEY_SET,
    localparam int unsigned PW = $clog2(NUM_KEYS + 1)
) (
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [PW-1:0]     progress_i,
    output key_event_t        evt_o
);

    logic [NUM_KEYS-1:0] hit;

    // One comparator per key word.
    for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cmp
        assign hit[g] = (wdata_i == KEYS[g]);
    end

    // Pick the comparator for the step currently expected.
    logic exp_hit;
    always_comb begin
        exp_hit = 1'b0;
        for (int i = 0; i < NUM_KEYS; i++) begin
            if (progress_i == PW'(i)) exp_hit = hit[i];
        end
    end

    assign evt_o.wr           = wr_i;
    assign evt_o.hit_expected = exp_hit;
    assign evt_o.hit_first    = hit[0];

endmodule

// File: rtl/keyseq_fsm.sv
module keyseq_fsm
    import keyseq_pkg::*;
#(
    parameter int unsigned NUM_KEYS = KEY_CNT,
    localparam int unsigned PW = $clog2(NUM_KEYS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  key_event_t    evt_i,
    output logic [PW-1:0] progress_o,
    output logic          grant_o
);

    localparam logic [PW-1:0] OPEN_ST = PW'(NUM_KEYS);
    localparam logic [PW-1:0] START   = '0;

    logic [PW-1:0] prog_q, prog_d;
    logic          grant_q;

    always_comb begin
        prog_d = prog_q;
        if (evt_i.wr) begin
            if (prog_q == OPEN_ST) begin
                prog_d = START;             // any write relocks
            end else if (evt_i.hit_expected) begin
                prog_d = prog_q + PW'(1);
            end else if (evt_i.hit_first) begin
                prog_d = PW'(1);            // restart counts as step one
            end else begin
                prog_d = START;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_q  <= START;
            grant_q <= 1'b0;
        end else begin
            prog_q  <= prog_d;
            grant_q <= (prog_d == OPEN_ST);
        end
    end

    assign progress_o = prog_q;
    assign grant_o    = grant_q;

endmodule

// File: rtl/keyseq_unlock.sv
module keyseq_unlock
    import keyseq_pkg::*;
#(
    parameter int unsigned DATA_W   = KEY_W,
    parameter int unsigned NUM_KEYS = KEY_CNT,
    parameter logic [NUM_KEYS-1:0][DATA_W-1:0] KEYS = KEY_SET
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              key_wr_i,
    input  logic [DATA_W-1:0] key_wdata_i,
    output logic [DATA_W-1:0] key_rdata_o,
    output logic              access_grant_o
);

    localparam int unsigned PW = $clog2(NUM_KEYS + 1);

    key_event_t    evt;
    logic [PW-1:0] progress;

    keyseq_match #(
        .DATA_W   (DATA_W),
        .NUM_KEYS (NUM_KEYS),
        .KEYS     (KEYS)
    ) match_i (
        .wr_i       (key_wr_i),
        .wdata_i    (key_wdata_i),
        .progress_i (progress),
        .evt_o      (evt)
    );

    keyseq_fsm #(
        .NUM_KEYS (NUM_KEYS)
    ) fsm_i (
        .clk        (clk),
        .rst        (rst),
        .evt_i      (evt),
        .progress_o (progress),
        .grant_o    (access_grant_o)
    );

    // Register is write-only: reads never expose the keys or the progress.
    assign key_rdata_o = '0;

endmodule

// File: rtl/keyseq_unlock_chk.sv
module keyseq_unlock_chk #(
    parameter int unsigned DATA_W = 32,
    parameter logic [DATA_W-1:0] LAST_KEY = '0
) (
    input logic              clk,
    input logic              rst,
    input logic              key_wr_i,
    input logic [DATA_W-1:0] key_wdata_i,
    input logic [DATA_W-1:0] key_rdata_o,
    input logic              access_grant_o
);

    AST_RESET_LOCKED: assert property (@(posedge clk)
        rst |=> !access_grant_o);                                   // R1

    AST_RISE_ON_LAST_KEY: assert property (@(posedge clk) disable iff (rst)
        $rose(access_grant_o) |-> $past(key_wr_i && key_wdata_i == LAST_KEY)); // R2

    AST_ANY_WRITE_RELOCKS: assert property (@(posedge clk) disable iff (rst)
        (access_grant_o && key_wr_i) |=> !access_grant_o);          // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !key_wr_i |=> $stable(access_grant_o));                     // R8

    always_comb begin
        AST_READ_ZERO: assert (key_rdata_o == '0);                  // R9
    end

endmodule

bind keyseq_unlock keyseq_unlock_chk #(
    .DATA_W   (DATA_W),
    .LAST_KEY (KEYS[NUM_KEYS-1])
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .key_wr_i       (key_wr_i),
    .key_wdata_i    (key_wdata_i),
    .key_rdata_o    (key_rdata_o),
    .access_grant_o (access_grant_o)
);

// File: tb/keyseq_unlock_tb_top.sv
`timescale 1ns/1ps
module keyseq_unlock_tb_top;

    localparam logic [31:0] K0 = 32'h3A7F_5CA3;
    localparam logic [31:0] K1 = 32'hA1E3_4F20;
    localparam logic [31:0] K2 = 32'h9608_B2C1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        key_wr_i = 1'b0;
    logic [31:0] key_wdata_i = '0;
    logic [31:0] key_rdata_o;
    logic        access_grant_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    keyseq_unlock dut_i (
        .clk            (clk),
        .rst            (rst),
        .key_wr_i       (key_wr_i),
        .key_wdata_i    (key_wdata_i),
        .key_rdata_o    (key_rdata_o),
        .access_grant_o (access_grant_o)
    );

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s grant actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_rd(input string req);
        checks++;
        if (key_rdata_o !== 32'h0) begin
            errors++;
            $display("FAIL %s rdata actual=%h expected=00000000", req, key_rdata_o);
        end
    endtask

    // One write strobe; returns at the following falling edge.
    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        key_wr_i    = 1'b1;
        key_wdata_i = d;
        @(negedge clk);
        key_wr_i    = 1'b0;
        key_wdata_i = $urandom;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(access_grant_o, 1'b0, "R1 after reset");
        chk_rd("R9 after reset");
        wr(K1); wr(K2);
        chk(access_grant_o, 1'b0, "R1 no progress kept");
    endtask

    task automatic t_basic_timing();
        do_reset();
        wr(K0); wr(K1);
        @(negedge clk);
        key_wr_i = 1'b1; key_wdata_i = K2;
        #1;
        chk(access_grant_o, 1'b0, "R3 before completing edge");
        @(negedge clk);
        key_wr_i = 1'b0;
        chk(access_grant_o, 1'b1, "R2 unlocked");
        chk(access_grant_o, 1'b1, "R3 after completing edge");
        chk_rd("R9 while unlocked");
        // relock timing
        @(negedge clk);
        key_wr_i = 1'b1; key_wdata_i = 32'h1234_5678;
        #1;
        chk(access_grant_o, 1'b1, "R3 before relock edge");
        @(negedge clk);
        key_wr_i = 1'b0;
        chk(access_grant_o, 1'b0, "R6 relock by arbitrary word");
    endtask

    task automatic t_wrong_steps();
        do_reset();
        wr(K0); wr(32'hDEAD_BEEF); wr(K1); wr(K2);
        chk(access_grant_o, 1'b0, "R4 wrong second word");
        wr(K0); wr(K1); wr(K1); wr(K2);
        chk(access_grant_o, 1'b0, "R4 wrong third word");
        wr(K0); wr(K1); wr(K0); wr(K2);
        chk(access_grant_o, 1'b0, "R4 first key at step three");
    endtask

    task automatic t_first_restart();
        do_reset();
        wr(K0); wr(K0); wr(K1); wr(K2);
        chk(access_grant_o, 1'b1, "R5 repeated first key");
        wr(K2);
        do_reset();
        wr(K0); wr(K1); wr(K0); wr(K1); wr(K2);
        chk(access_grant_o, 1'b1, "R5 first key at step three restarts");
    endtask

    task automatic t_relock();
        do_reset();
        wr(K0); wr(K1); wr(K2);
        wr(K2);
        chk(access_grant_o, 1'b0, "R6 relock by third key");
        wr(K0); wr(K1); wr(K2);
        chk(access_grant_o, 1'b1, "R2 unlock again");
        wr(K0);
        chk(access_grant_o, 1'b0, "R6 relock by first key");
        wr(K1); wr(K2);
        chk(access_grant_o, 1'b0, "R7 relocking write not a step");
    endtask

    task automatic t_idle_gaps();
        do_reset();
        wr(K0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); key_wdata_i = (i % 2 == 0) ? 32'hFFFF_0000 : K0;
        end
        wr(K1);
        repeat (4) @(negedge clk);
        chk(access_grant_o, 1'b0, "R8 still locked in gap");
        wr(K2);
        chk(access_grant_o, 1'b1, "R8 progress kept across gaps");
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); key_wdata_i = $urandom;
        end
        chk(access_grant_o, 1'b1, "R8 grant held while idle");
        chk_rd("R9 idle unlocked");
    endtask

    initial begin
        t_reset();
        t_basic_timing();
        t_wrong_steps();
        t_first_restart();
        t_relock();
        t_idle_gaps();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule